// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the device-side command engine of a parallel NOR-style flash. It holds a small internal word array. It watches chip-select, write-strobe and read-strobe bus cycles, which are sampled by one register stage on the system clock. A write cycle is taken when the write strobe rises while chip-select is low. Each write cycle carries an address and a data byte. Unlock-prefixed sequences of these cycles start timed program and erase operations.

While an operation runs, the ready/busy pin is held low and any read returns a polling status word instead of array data. A sector erase can be paused, so that other sectors can be read or programmed, and then continued. A fast-program mode drops the unlock prefix. Per-sector lock pins and a write-inhibit pin guard the array. The data path is 16 bits wide, or 8 bits on the low lane in byte mode. Command-address matching uses the word address bits [10:0] in both modes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, ry_by is 1 and every word of the array reads 16'hFFFF in word mode.
- R2: The write cycles AA@555, 55@2AA and A0@555, followed by an address/data write, start a program. ry_by goes low for exactly PROG_CYC clock cycles, and the word then reads as old AND data.
- R3: While a program runs, any read returns DQ7 equal to the complement of the programmed bit 7. DQ6 flips on every read, and all other bits are 0.
- R4: Programming can only clear bits. Writing 1 over a 0 leaves it 0.
- R5: When byte_mode is 1, addr is a byte address and addr[0]=1 selects the upper byte of the word. The unlock addresses become AAA and 555. Reads return the selected byte on DQ7..DQ0, with DQ15..DQ8 equal to 0.
- R6: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at an address inside the target sector, erases that sector. A sector is 16 words, selected by word address bits [5:4]. All of its words read 16'hFFFF afterwards and other sectors are unchanged. While the erase runs, reads return DQ7=0, a flipping DQ6, and 0 in all other bits.
- R7: The same prefix followed by 10@555 erases every sector whose lock bit is 0. Locked sectors keep their data.
- R8: A program or erase aimed at a sector whose sect_lock bit is 1 is dropped. ry_by stays 1, the data is unchanged, and the block returns to array read.
- R9: A write of F0, or any cycle that does not match the expected step, returns the block to array read. The sequence must then restart from its first unlock cycle.
- R10: The cycles AA@555, 55@2AA, 20@555 enter fast-program mode. There, A0 followed by an address/data write programs a word. The writes 90 and then 00 leave the mode.
- R11: A write of B0 during a sector erase suspends it, and ry_by goes to 1. Reads of the erasing sector return 16'h0080, and reads of other sectors return array data. A full program sequence to another sector runs and returns to suspend. A program sequence aimed at the erasing sector is dropped. A write of 30 resumes the erase, which then completes.
- R12: While wr_inhibit is 1, every write cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; a cycle is taken on its rise |
| oe_n | input | 1 | Read strobe, active low |
| byte_mode | input | 1 | 1 selects the 8-bit data lane |
| wr_inhibit | input | 1 | Low-supply write block |
| sect_lock | input | 4 | Per-sector lock bits |
| addr | input | 12 | Word address, or byte address in byte mode |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data or status |
| dq_oe | output | 1 | Read data valid (chip select and read strobe both low) |
| ry_by | output | 1 | 1 when ready, 0 while busy |

## Verification
The assertions take the bus strobes as clean levels that last for at least one clock each. They also take address and data as stable for the whole write strobe, and sect_lock as unchanged while an operation is busy. The protection and busy-start checks depend on these. The stimulus uses one write task and one read task, which hold every strobe for two or three clocks with address and data fixed. The lock pins are changed only while the block is idle in array read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PGM, ST_E1, ST_E2, ST_E3,
    ST_BYP, ST_BYP_PGM, ST_BYP_X, ST_PBUSY, ST_EBUSY, ST_SUSP
  } fc_state_t;

  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] C_KEY1  = 8'hAA;
  localparam logic [7:0] C_KEY2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_FAST  = 8'h20;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_HOLD  = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] C_FEXIT = 8'h90;
  localparam logic [7:0] C_FDONE = 8'h00;

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          byte_mode,
  input  logic          wr_inhibit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output logic          byte_q,
  output logic          inh_q,
  output logic          wr_evt,
  output logic          rd_fall,
  output logic          rd_act
);

  logic ce_q, we_q, we_d, oe_q, oe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      we_d   <= 1'b1;
      oe_q   <= 1'b1;
      oe_d   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
      byte_q <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      we_q   <= we_n;
      we_d   <= we_q;
      oe_q   <= oe_n;
      oe_d   <= oe_q;
      addr_q <= addr;
      din_q  <= dq_in;
      byte_q <= byte_mode;
      inh_q  <= wr_inhibit;
    end
  end

  // write taken on the rising write strobe; blocked by the inhibit pin
  assign wr_evt  = !ce_q && !we_d && we_q && !inh_q;
  assign rd_fall = !ce_q && oe_d && !oe_q;
  assign rd_act  = !ce_q && !oe_q;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int WL        = 6,
  parameter int SL        = 2,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_evt,
  input  logic                 rd_fall,
  input  logic                 inh_q,
  input  logic                 byte_q,
  input  logic [AW-1:0]        addr_q,
  input  logic [DW-1:0]        din_q,
  input  logic [(1<<SL)-1:0]   lock,
  output logic                 prog_en,
  output logic [WL-1:0]        prog_idx,
  output logic [DW-1:0]        prog_data,
  output logic                 prog_byte,
  output logic                 prog_hi,
  output logic                 pre_en,
  output logic                 fill_en,
  output logic [(1<<SL)-1:0]   ers_mask,
  output logic                 busy_pgm,
  output logic                 busy_ers,
  output logic                 in_susp,
  output logic                 pd7,
  output logic                 tog
);

  localparam int NS  = 1 << SL;
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);

  fc_state_t      st;
  logic [PCW-1:0] pcnt;
  logic [ECW-1:0] ecnt;
  logic           ret_fast, ers_chip, pre_pend;

  logic [AW-2:0]  wa;
  logic [7:0]     cd;
  logic           k1, k2, blocked;
  logic [SL-1:0]  sec;
  fc_state_t      home;

  assign wa      = byte_q ? addr_q[AW-1:1] : addr_q[AW-2:0];
  assign cd      = din_q[7:0];
  assign k1      = (wa[CMD_AW-1:0] == ADR_KEY1);
  assign k2      = (wa[CMD_AW-1:0] == ADR_KEY2);
  assign sec     = wa[WL-1:WL-SL];
  assign blocked = lock[sec] || (in_susp && ers_mask[sec]);
  assign home    = in_susp ? ST_SUSP : ST_READ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_READ;
      pcnt      <= '0;
      ecnt      <= '0;
      ret_fast  <= 1'b0;
      ers_chip  <= 1'b0;
      pre_pend  <= 1'b0;
      in_susp   <= 1'b0;
      ers_mask  <= '0;
      prog_idx  <= '0;
      prog_data <= '0;
      prog_byte <= 1'b0;
      prog_hi   <= 1'b0;
      tog       <= 1'b0;
    end else begin
      pre_pend <= 1'b0;
      if (rd_fall && (st == ST_PBUSY || st == ST_EBUSY)) tog <= ~tog;
      unique case (st)
        ST_READ: if (wr_evt) st <= (k1 && cd == C_KEY1) ? ST_UL1 : ST_READ;
        ST_UL1:  if (wr_evt) st <= (k2 && cd == C_KEY2) ? ST_UL2 : home;
        ST_UL2: if (wr_evt) begin
          if (k1 && cd == C_PROG)                  st <= ST_PGM;
          else if (k1 && cd == C_ERASE && !in_susp) st <= ST_E1;
          else if (k1 && cd == C_FAST && !in_susp)  st <= ST_BYP;
          else                                      st <= home;
        end
        ST_PGM, ST_BYP_PGM: if (wr_evt) begin
          if (blocked) begin
            st <= (st == ST_BYP_PGM) ? ST_BYP : home;
          end else begin
            prog_idx  <= wa[WL-1:0];
            prog_data <= din_q;
            prog_byte <= byte_q;
            prog_hi   <= byte_q & addr_q[0];
            ret_fast  <= (st == ST_BYP_PGM);
            pcnt      <= PCW'(PROG_CYC - 1);
            st        <= ST_PBUSY;
          end
        end
        ST_E1: if (wr_evt) st <= (k1 && cd == C_KEY1) ? ST_E2 : ST_READ;
        ST_E2: if (wr_evt) st <= (k2 && cd == C_KEY2) ? ST_E3 : ST_READ;
        ST_E3: if (wr_evt) begin
          if (k1 && cd == C_CHIP && (~lock != '0)) begin
            ers_mask <= ~lock;
            ers_chip <= 1'b1;
            ecnt     <= ECW'(ERASE_CYC - 1);
            pre_pend <= 1'b1;
            st       <= ST_EBUSY;
          end else if (cd == C_SECT && !lock[sec]) begin
            ers_mask <= NS'(1) << sec;
            ers_chip <= 1'b0;
            ecnt     <= ECW'(ERASE_CYC - 1);
            pre_pend <= 1'b1;
            st       <= ST_EBUSY;
          end else begin
            st <= ST_READ;
          end
        end
        ST_BYP: if (wr_evt) begin
          if (cd == C_PROG)       st <= ST_BYP_PGM;
          else if (cd == C_FEXIT) st <= ST_BYP_X;
        end
        ST_BYP_X: if (wr_evt) st <= (cd == C_FDONE) ? ST_READ : ST_BYP;
        ST_PBUSY: begin
          if (pcnt == '0) st <= ret_fast ? ST_BYP : home;
          else            pcnt <= pcnt - 1'b1;
        end
        ST_EBUSY: begin
          if (ecnt == '0) begin
            st       <= ST_READ;
            ers_mask <= '0;
          end else if (wr_evt && cd == C_HOLD && !ers_chip) begin
            st      <= ST_SUSP;
            in_susp <= 1'b1;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        ST_SUSP: if (wr_evt) begin
          if (cd == C_RESUME) begin
            st      <= ST_EBUSY;
            in_susp <= 1'b0;
          end else if (k1 && cd == C_KEY1) begin
            st <= ST_UL1;
          end
        end
        default: st <= ST_READ;
      endcase
    end
  end

  assign busy_pgm = (st == ST_PBUSY);
  assign busy_ers = (st == ST_EBUSY);
  assign prog_en  = busy_pgm && (pcnt == '0);
  assign fill_en  = busy_ers && (ecnt == '0);
  assign pre_en   = pre_pend;
  assign pd7      = prog_data[7];

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pgm || busy_ers) |-> $past(wr_evt)); // R2

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && st == ST_READ) |=> (st == ST_READ)); // R12

  AST_SUSP_ONLY_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_susp) |-> !ers_chip); // R11

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DW = 16,
  parameter int WL = 6,
  parameter int SL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_en,
  input  logic [WL-1:0]      prog_idx,
  input  logic [DW-1:0]      prog_data,
  input  logic               prog_byte,
  input  logic               prog_hi,
  input  logic               pre_en,
  input  logic               fill_en,
  input  logic [(1<<SL)-1:0] ers_mask,
  input  logic [(1<<SL)-1:0] lock,
  input  logic [WL-1:0]      rd_idx,
  output logic [DW-1:0]      rd_word
);

  localparam int DEPTH  = 1 << WL;
  localparam int SWORDS = 1 << (WL - SL);
  localparam int BW     = DW / 2;

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] w;
    logic          hit, in_ers;
    assign hit    = prog_en && (prog_idx == WL'(g));
    assign in_ers = ers_mask[g / SWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w <= '1;
      end else if (fill_en && in_ers) begin
        w <= '1;
      end else if (pre_en && in_ers) begin
        w <= '0;
      end else if (hit) begin
        if (!prog_byte)   w <= w & prog_data;
        else if (prog_hi) w[DW-1:BW] <= w[DW-1:BW] & prog_data[BW-1:0];
        else              w[BW-1:0]  <= w[BW-1:0] & prog_data[BW-1:0];
      end
    end
    assign words[g] = w;
  end

  assign rd_word = words[rd_idx];

  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> !lock[prog_idx[WL-1:WL-SL]]); // R8

  AST_LOCKED_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en || pre_en) |-> ((ers_mask & lock) == '0)); // R8

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int WL        = 6,
  parameter int SL        = 2,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               byte_mode,
  input  logic               wr_inhibit,
  input  logic [(1<<SL)-1:0] sect_lock,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      dq_in,
  output logic [DW-1:0]      dq_out,
  output logic               dq_oe,
  output logic               ry_by
);

  localparam int NS = 1 << SL;
  localparam int BW = DW / 2;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic          byte_q, inh_q, wr_evt, rd_fall, rd_act;

  logic          prog_en, prog_byte, prog_hi, pre_en, fill_en;
  logic [WL-1:0] prog_idx, rd_idx;
  logic [DW-1:0] prog_data, rd_word;
  logic [NS-1:0] ers_mask;
  logic          busy_pgm, busy_ers, in_susp, pd7, tog;

  flash_bus_sampler #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .wr_inhibit(wr_inhibit), .addr(addr), .dq_in(dq_in),
    .addr_q(addr_q), .din_q(din_q), .byte_q(byte_q), .inh_q(inh_q),
    .wr_evt(wr_evt), .rd_fall(rd_fall), .rd_act(rd_act)
  );

  flash_cmd_fsm #(.AW(AW), .DW(DW), .WL(WL), .SL(SL),
                  .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_fall(rd_fall), .inh_q(inh_q),
    .byte_q(byte_q), .addr_q(addr_q), .din_q(din_q), .lock(sect_lock),
    .prog_en(prog_en), .prog_idx(prog_idx), .prog_data(prog_data),
    .prog_byte(prog_byte), .prog_hi(prog_hi), .pre_en(pre_en), .fill_en(fill_en),
    .ers_mask(ers_mask), .busy_pgm(busy_pgm), .busy_ers(busy_ers),
    .in_susp(in_susp), .pd7(pd7), .tog(tog)
  );

  flash_array #(.DW(DW), .WL(WL), .SL(SL)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_idx(prog_idx),
    .prog_data(prog_data), .prog_byte(prog_byte), .prog_hi(prog_hi),
    .pre_en(pre_en), .fill_en(fill_en), .ers_mask(ers_mask), .lock(sect_lock),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  logic          rd_hi;
  logic [SL-1:0] rd_sec;
  logic [DW-1:0] val;

  assign rd_idx = byte_q ? addr_q[WL:1] : addr_q[WL-1:0];
  assign rd_hi  = byte_q & addr_q[0];
  assign rd_sec = rd_idx[WL-1:WL-SL];

  always_comb begin
    if (busy_pgm)
      val = DW'({~pd7, tog, 6'b0});
    else if (busy_ers)
      val = DW'({1'b0, tog, 6'b0});
    else if (in_susp && ers_mask[rd_sec])
      val = DW'(8'h80);
    else if (byte_q)
      val = DW'(rd_hi ? rd_word[DW-1:BW] : rd_word[BW-1:0]);
    else
      val = rd_word;
  end

  assign dq_oe  = rd_act;
  assign dq_out = dq_oe ? val : '0;
  assign ry_by  = !(busy_pgm || busy_ers);

  AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by && dq_oe) |-> (dq_out[DW-1:8] == '0 && dq_out[5:0] == '0)); // R3

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 300;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic        byte_mode = 1'b0, wr_inhibit = 1'b0;
  logic [3:0]  sect_lock = 4'b0000;
  logic [11:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe, ry_by;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .wr_inhibit(wr_inhibit), .sect_lock(sect_lock),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int run = 0, last_run = 0;
  logic [15:0] mem_m [64];

  // behavioural busy-run monitor
  always @(negedge clk) begin
    if (rst_n && !ry_by) run++;
    else if (run > 0) begin last_run = run; run = 0; end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 0; addr = a; dq_in = d; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    repeat (2) @(negedge clk);
    ce_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    ce_n = 0; oe_n = 0; addr = a;
    repeat (3) @(negedge clk);
    v = dq_out;
    oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ry_by && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    if (n >= 5000) check(req, 16'h0, 16'h1);
  endtask

  task automatic unlock(input bit bm);
    bus_wr(bm ? 12'hAAA : 12'h555, 16'h00AA);
    bus_wr(bm ? 12'h555 : 12'h2AA, 16'h0055);
  endtask

  task automatic prog(input logic [11:0] wa, input logic [15:0] d);
    unlock(0);
    bus_wr(12'h555, 16'h00A0);
    bus_wr(wa, d);
    if (!sect_lock[wa[5:4]]) mem_m[wa[5:0]] &= d;
  endtask

  task automatic erase_prefix;
    unlock(0);
    bus_wr(12'h555, 16'h0080);
    unlock(0);
  endtask

  task automatic m_erase(input logic [3:0] m);
    for (int i = 0; i < 64; i++) if (m[i/16]) mem_m[i] = 16'hFFFF;
  endtask

  task automatic cmp_word(input string req, input logic [11:0] wa);
    logic [15:0] v;
    bus_rd(wa, v);
    check(req, v, mem_m[wa[5:0]]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL WDOG act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v1, v2;
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 ready", 16'(ry_by), 16'h1);
    cmp_word("R1 word0", 12'd0);
    cmp_word("R1 word63", 12'd63);

    // data for the later lock test, written while unlocked
    prog(12'd50, 16'h2222);
    wait_ready("R2 timeout");
    sect_lock = 4'b1000;
    @(negedge clk);

    // R2/R3 four-cycle program with polling
    prog(12'd3, 16'h1234);
    check("R2 busy", 16'(ry_by), 16'h0);
    bus_rd(12'd3, v1);
    bus_rd(12'd9, v2);
    check("R3 status", v1 & 16'hFFBF, 16'h0080);
    check("R3 toggle", 16'(v1[6] ^ v2[6]), 16'h1);
    wait_ready("R2 timeout");
    check("R2 busy length", 16'(last_run), 16'(PROG_CYC));
    cmp_word("R2 data", 12'd3);

    // R4 only clears bits
    prog(12'd3, 16'hFFFF); wait_ready("R4 timeout");
    cmp_word("R4 no set", 12'd3);
    prog(12'd3, 16'hF0F0); wait_ready("R4 timeout");
    cmp_word("R4 clear", 12'd3);
    check("R4 value", mem_m[3], 16'h1030);

    // R9 F0 and broken sequence
    unlock(0);
    bus_wr(12'h555, 16'h00F0);
    bus_wr(12'd3, 16'h0000);
    cmp_word("R9 after F0", 12'd3);
    bus_wr(12'h555, 16'h00AA);
    bus_wr(12'h2AA, 16'h0011);
    bus_wr(12'h555, 16'h00A0);
    bus_wr(12'd4, 16'h0000);
    check("R9 ready", 16'(ry_by), 16'h1);
    cmp_word("R9 word4", 12'd4);

    // R12 inhibit
    wr_inhibit = 1;
    unlock(0);
    bus_wr(12'h555, 16'h00A0);
    bus_wr(12'd5, 16'h0000);
    wr_inhibit = 0;
    check("R12 ready", 16'(ry_by), 16'h1);
    cmp_word("R12 word5", 12'd5);

    // R5 byte mode, upper byte of word 6
    byte_mode = 1;
    unlock(1);
    bus_wr(12'hAAA, 16'h00A0);
    bus_wr(12'd13, 16'h005A);
    mem_m[6][15:8] &= 8'h5A;
    wait_ready("R5 timeout");
    bus_rd(12'd13, v1);
    check("R5 byte hi", v1, 16'h005A);
    bus_rd(12'd12, v1);
    check("R5 byte lo", v1, 16'h00FF);
    byte_mode = 0;
    @(negedge clk);
    cmp_word("R5 word view", 12'd6);

    // R8 locked sector 3
    prog(12'd48, 16'h0000);
    check("R8 prog ready", 16'(ry_by), 16'h1);
    cmp_word("R8 word48", 12'd48);
    erase_prefix();
    bus_wr(12'd48, 16'h0030);
    check("R8 erase ready", 16'(ry_by), 16'h1);
    cmp_word("R8 word50", 12'd50);

    // R6 sector erase of sector 0
    prog(12'd20, 16'hABCD); wait_ready("R6 timeout");
    erase_prefix();
    bus_wr(12'd2, 16'h0030);
    check("R6 busy", 16'(ry_by), 16'h0);
    bus_rd(12'd20, v1);
    bus_rd(12'd20, v2);
    check("R6 status", v1 & 16'hFFBF, 16'h0000);
    check("R6 toggle", 16'(v1[6] ^ v2[6]), 16'h1);
    wait_ready("R6 timeout");
    m_erase(4'b0001);
    cmp_word("R6 word3", 12'd3);
    cmp_word("R6 word6", 12'd6);
    cmp_word("R6 word20 kept", 12'd20);

    // R10 fast-program mode
    unlock(0);
    bus_wr(12'h555, 16'h0020);
    bus_wr(12'd0, 16'h00A0);
    bus_wr(12'd21, 16'h00FF);
    mem_m[21] &= 16'h00FF;
    check("R10 busy", 16'(ry_by), 16'h0);
    wait_ready("R10 timeout");
    bus_wr(12'd0, 16'h00A0);
    bus_wr(12'd22, 16'h1111);
    mem_m[22] &= 16'h1111;
    wait_ready("R10 timeout");
    cmp_word("R10 word21", 12'd21);
    cmp_word("R10 word22", 12'd22);
    bus_wr(12'd0, 16'h0090);
    bus_wr(12'd0, 16'h0000);
    bus_wr(12'd0, 16'h00A0);
    bus_wr(12'd23, 16'h0000);
    check("R10 exited", 16'(ry_by), 16'h1);
    cmp_word("R10 word23", 12'd23);

    // R11 suspend and resume of sector 1 erase
    erase_prefix();
    bus_wr(12'd16, 16'h0030);
    repeat (10) @(negedge clk);
    bus_wr(12'd0, 16'h00B0);
    check("R11 ready in suspend", 16'(ry_by), 16'h1);
    bus_rd(12'd20, v1);
    check("R11 erasing sector", v1, 16'h0080);
    cmp_word("R11 other sector", 12'd40);
    prog(12'd41, 16'h1357);
    check("R11 prog busy", 16'(ry_by), 16'h0);
    wait_ready("R11 timeout");
    cmp_word("R11 prog data", 12'd41);
    unlock(0);
    bus_wr(12'h555, 16'h00A0);
    bus_wr(12'd25, 16'h0000);
    check("R11 blocked prog", 16'(ry_by), 16'h1);
    bus_wr(12'd0, 16'h0030);
    check("R11 resumed", 16'(ry_by), 16'h0);
    wait_ready("R11 timeout");
    m_erase(4'b0010);
    cmp_word("R11 word20", 12'd20);
    cmp_word("R11 word25", 12'd25);
    cmp_word("R11 word41", 12'd41);

    // R7 chip erase with sector 3 locked
    erase_prefix();
    bus_wr(12'h555, 16'h0010);
    check("R7 busy", 16'(ry_by), 16'h0);
    wait_ready("R7 timeout");
    m_erase(4'b0111);
    cmp_word("R7 word41", 12'd41);
    cmp_word("R7 word50 locked", 12'd50);
    check("R7 locked value", mem_m[50], 16'h2222);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule